// File: doc/BRIEF.md
# Potentiometer Wiper and Data Register Bank

This block sits behind a serial command decoder and holds all the register state of a digitally controlled potentiometer. It keeps a volatile wiper register whose 10-bit code would select one of 1024 taps, where 000h is the low end of the resistor array and 3FFh the high end. It also keeps four 10-bit data registers that stand in for nonvolatile storage. The decoder hands it one command per `cmd_valid` pulse. It also sends a `cs_rise` pulse when the frame ends, and that pulse is what commits a pending nonvolatile update.

Writes to the wiper and loads of a stored position into the wiper take effect at once. A store into a data register, whether from host data or from the current wiper, runs a timed busy cycle. During that cycle a write-in-progress flag is high, and the stored value changes only when the cycle ends. A low level on the write-protect input at frame end cancels the store. When storage is initialised (`cold_n`) or any reset is applied (`rst_n`), the wiper recalls the contents of data register 0.

Top module: `potbank_top`

## Requirements
- R1: While `rst_n` is low the wiper is loaded from data register 0, so after reset `wiper_code` equals the stored DR0 value. `cold_n` low reloads all data registers from `DR_INIT`, and `rst_n` alone leaves them unchanged. After reset `wip` and `rd_data` are 0.
- R2: Command `cmd_op`=1 (wiper write) sets `wiper_code` to `cmd_wdata` on the clock edge that samples it. It works whatever the level of `wp_n` and `wip`.
- R3: Command `cmd_op`=4 (load register into wiper) sets `wiper_code` to data register `cmd_sel` on the sampling edge, and it never sets `wip`.
- R4: `wiper_code` changes only through R1, R2 or R3.
- R5: Command `cmd_op`=3 (store data into DR `cmd_sel`) and command `cmd_op`=5 (store the wiper into DR `cmd_sel`) start nothing by themselves. `wip` rises one cycle after the first `cs_rise` that follows them. A `cs_rise` with no pending store does nothing.
- R6: `wip` stays high for exactly `BUSY_CYCLES` cycles. The data register takes its new value when `wip` falls, and reads during the busy period return the old value.
- R7: If `wp_n` is low in the cycle of `cs_rise`, the pending store is dropped: `wip` stays low and the register keeps its value.
- R8: While `wip` is high, commands 3 and 5 are ignored, so no further store follows the current one.
- R9: Command 5 stores the wiper value present in the cycle the command is sampled, even if the wiper changes before `cs_rise`.
- R10: One cycle after a read command, `rd_data` holds the requested value. Command 0 returns the wiper, command 2 returns DR `cmd_sel`, and command 6 returns `wip` in bit 0 with all other bits 0. Any other command, including the reserved code 7, leaves `rd_data` and all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_n | input | 1 | Active-low storage initialisation; loads DR_INIT into the data registers |
| rst_n | input | 1 | Active-low reset; clears the busy state and recalls DR0 into the wiper |
| cmd_valid | input | 1 | One-cycle command strobe from the decoder |
| cmd_op | input | 3 | Command code (encoding in R2, R3, R5, R10) |
| cmd_sel | input | 2 | Data register index |
| cmd_wdata | input | 10 | Write data for wiper or data register |
| cs_rise | input | 1 | One-cycle pulse at end of frame; commits a pending store |
| wp_n | input | 1 | Active-low write protect for data register stores |
| wiper_code | output | 10 | Current wiper tap code |
| rd_data | output | 10 | Registered read result |
| wip | output | 1 | Write in progress |

## Verification
A wiper write or load shows on `wiper_code` right after the edge that samples the command. A read shows on `rd_data` one cycle later. `wip` rises one cycle after the qualifying `cs_rise` and stays high for `BUSY_CYCLES` cycles. The bench drives each input at a falling edge and samples outputs at the next falling edge, so every check falls one clock after its stimulus. The length of the busy period is counted one falling edge at a time. Stored values are read back only after `wip` has dropped, except in the check that looks for the old value during the busy period.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DREG  = 3'd2,
    OP_WR_DREG  = 3'd3,
    OP_XFR_D2W  = 3'd4,
    OP_XFR_W2D  = 3'd5,
    OP_RD_STAT  = 3'd6,
    OP_RSVD     = 3'd7
  } pot_op_e;

  // commands that request a nonvolatile store
  function automatic logic op_is_store(input logic [2:0] op);
    return (op == OP_WR_DREG) || (op == OP_XFR_W2D);
  endfunction

  // commands that load the wiper at once
  function automatic logic op_loads_wiper(input logic [2:0] op);
    return (op == OP_WR_WIPER) || (op == OP_XFR_D2W);
  endfunction

  function automatic logic op_is_read(input logic [2:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_DREG) || (op == OP_RD_STAT);
  endfunction

endpackage

// File: rtl/potbank_nvstore.sv
module potbank_nvstore #(
  parameter int W           = 10,
  parameter int NREG        = 4,
  parameter int SELW        = 2,
  parameter int BUSY_CYCLES = 1000,
  parameter logic [NREG*W-1:0] DR_INIT = '0
) (
  input  logic              clk,
  input  logic              cold_n,
  input  logic              rst_n,
  input  logic              st_req,
  input  logic [SELW-1:0]   st_sel,
  input  logic [W-1:0]      st_data,
  input  logic              cs_rise,
  input  logic              wp_n,
  output logic [NREG*W-1:0] dr_flat,
  output logic              wip,
  output logic              commit_start,
  output logic              commit_done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic            pend_valid;
  logic [SELW-1:0] pend_sel;
  logic [W-1:0]    pend_data;
  logic [CW-1:0]   busy_cnt;
  logic            wip_q;

  assign commit_start = cs_rise && pend_valid && wp_n && !wip_q;
  assign commit_done  = wip_q && (busy_cnt == '0);
  assign wip          = wip_q;

  // pending store: captured in the frame, dropped at frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_sel   <= '0;
      pend_data  <= '0;
    end else if (cs_rise) begin
      pend_valid <= 1'b0;
    end else if (st_req) begin
      pend_valid <= 1'b1;
      pend_sel   <= st_sel;
      pend_data  <= st_data;
    end
  end

  // busy timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q    <= 1'b0;
      busy_cnt <= '0;
    end else if (commit_start) begin
      wip_q    <= 1'b1;
      busy_cnt <= CW'(BUSY_CYCLES - 1);
    end else if (commit_done) begin
      wip_q    <= 1'b0;
    end else if (wip_q) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  // storage cells, one per register
  for (genvar gi = 0; gi < NREG; gi++) begin : g_cell
    always_ff @(posedge clk or negedge cold_n) begin
      if (!cold_n)
        dr_flat[gi*W +: W] <= DR_INIT[gi*W +: W];
      else if (commit_done && (pend_sel == SELW'(gi)))
        dr_flat[gi*W +: W] <= pend_data;
    end
  end

endmodule

// File: rtl/potbank_wiper.sv
module potbank_wiper #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] recall_val,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] wiper
);
  // recall is applied every cycle the reset is held
  always_ff @(posedge clk) begin
    if (!rst_n)
      wiper <= recall_val;
    else if (load_en)
      wiper <= load_val;
  end
endmodule

// File: rtl/potbank_readmux.sv
module potbank_readmux #(
  parameter int W    = 10,
  parameter int NREG = 4,
  parameter int SELW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [2:0]        op,
  input  logic [SELW-1:0]   sel,
  input  logic [W-1:0]      wiper,
  input  logic [NREG*W-1:0] dr_flat,
  input  logic              wip,
  output logic [W-1:0]      rd_data
);
  import potbank_pkg::*;

  function automatic logic [W-1:0] pick(input logic [2:0] o, input logic [SELW-1:0] s,
                                        input logic [W-1:0] wv, input logic [NREG*W-1:0] d,
                                        input logic st);
    case (o)
      OP_RD_DREG: return d[s*W +: W];
      OP_RD_STAT: return {{(W-1){1'b0}}, st};
      default:    return wv;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= pick(op, sel, wiper, dr_flat, wip);
  end
endmodule

// File: rtl/potbank_top.sv
module potbank_top #(
  parameter int W           = 10,
  parameter int NREG        = 4,
  parameter int BUSY_CYCLES = 1000,
  parameter logic [NREG*W-1:0] DR_INIT = '0
) (
  input  logic         clk,
  input  logic         cold_n,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [1:0]   cmd_sel,
  input  logic [9:0]   cmd_wdata,
  input  logic         cs_rise,
  input  logic         wp_n,
  output logic [9:0]   wiper_code,
  output logic [9:0]   rd_data,
  output logic         wip
);
  import potbank_pkg::*;
  localparam int SELW = 2;

  logic [NREG*W-1:0] dr_flat;
  logic              wiper_load;
  logic [W-1:0]      wiper_next;
  logic              store_req;
  logic [W-1:0]      store_data;
  logic              read_en;
  logic              commit_start;
  logic              commit_done;

  assign wiper_load = cmd_valid && op_loads_wiper(cmd_op);
  assign wiper_next = (cmd_op == OP_WR_WIPER) ? cmd_wdata : dr_flat[cmd_sel*W +: W];
  assign store_req  = cmd_valid && op_is_store(cmd_op) && !wip;
  assign store_data = (cmd_op == OP_WR_DREG) ? cmd_wdata : wiper_code;
  assign read_en    = cmd_valid && op_is_read(cmd_op);

  potbank_nvstore #(.W(W), .NREG(NREG), .SELW(SELW), .BUSY_CYCLES(BUSY_CYCLES),
                    .DR_INIT(DR_INIT)) u_store (
    .clk(clk), .cold_n(cold_n), .rst_n(rst_n),
    .st_req(store_req), .st_sel(cmd_sel), .st_data(store_data),
    .cs_rise(cs_rise), .wp_n(wp_n), .dr_flat(dr_flat), .wip(wip),
    .commit_start(commit_start), .commit_done(commit_done)
  );

  potbank_wiper #(.W(W)) u_wiper (
    .clk(clk), .rst_n(rst_n), .recall_val(dr_flat[W-1:0]),
    .load_en(wiper_load), .load_val(wiper_next), .wiper(wiper_code)
  );

  potbank_readmux #(.W(W), .NREG(NREG), .SELW(SELW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(read_en), .op(cmd_op), .sel(cmd_sel),
    .wiper(wiper_code), .dr_flat(dr_flat), .wip(wip), .rd_data(rd_data)
  );

endmodule

// File: rtl/potbank_sva.sv
module potbank_sva #(
  parameter int W           = 10,
  parameter int BUSY_CYCLES = 1000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic         cs_rise,
  input logic         wp_n,
  input logic [W-1:0] wiper_code,
  input logic [W-1:0] rd_data,
  input logic         wip,
  input logic         wiper_load,
  input logic         commit_start
);
  import potbank_pkg::*;
  localparam int CW = $clog2(BUSY_CYCLES + 2);

  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= '0;
    else if (wip) run_len <= run_len + 1'b1;
    else          run_len <= '0;
  end

  AST_WIPER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_code != $past(wiper_code)) |-> $past(wiper_load)); // R4
  AST_COMMIT_SETS_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> wip); // R5
  AST_WIP_NEEDS_UNPROTECTED_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise && wp_n)); // R7
  AST_LOAD_NO_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_XFR_D2W && !wip && !cs_rise) |=> !wip); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run_len == CW'(BUSY_CYCLES))); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CW'(BUSY_CYCLES)); // R6
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD_STAT) |=> (rd_data == {{(W-1){1'b0}}, $past(wip)})); // R10
endmodule

bind potbank_top potbank_sva #(.W(W), .BUSY_CYCLES(BUSY_CYCLES)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cs_rise(cs_rise), .wp_n(wp_n), .wiper_code(wiper_code), .rd_data(rd_data),
  .wip(wip), .wiper_load(wiper_load), .commit_start(commit_start)
);

// File: tb/potbank_top_tb.sv
module potbank_top_tb;
  localparam int BUSY = 8;
  localparam logic [39:0] INIT = {10'h3FF, 10'h000, 10'h155, 10'h2A5};

  logic clk = 0;
  logic cold_n = 0, rst_n = 0, cmd_valid = 0, cs_rise = 0, wp_n = 1;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_sel = 0;
  logic [9:0] cmd_wdata = 0;
  logic [9:0] wiper_code, rd_data;
  logic wip;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  potbank_top #(.BUSY_CYCLES(BUSY), .DR_INIT(INIT)) u_dut (
    .clk(clk), .cold_n(cold_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .cs_rise(cs_rise), .wp_n(wp_n), .wiper_code(wiper_code),
    .rd_data(rd_data), .wip(wip)
  );

  // op, sel, wdata, expected wiper, expected rd_data
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 2'd0, 10'h000, 10'h2A5, 10'h2A5},
    {3'd1, 2'd0, 10'h3FF, 10'h3FF, 10'h2A5},
    {3'd0, 2'd0, 10'h000, 10'h3FF, 10'h3FF},
    {3'd2, 2'd1, 10'h000, 10'h3FF, 10'h155},
    {3'd4, 2'd2, 10'h000, 10'h000, 10'h155},
    {3'd6, 2'd0, 10'h000, 10'h000, 10'h000},
    {3'd4, 2'd3, 10'h000, 10'h3FF, 10'h000},
    {3'd2, 2'd0, 10'h000, 10'h3FF, 10'h2A5},
    {3'd7, 2'd1, 10'h123, 10'h3FF, 10'h2A5},
    {3'd1, 2'd0, 10'h001, 10'h001, 10'h2A5},
    {3'd0, 2'd0, 10'h000, 10'h001, 10'h001},
    {3'd4, 2'd1, 10'h000, 10'h155, 10'h001}
  };

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [9:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic frame_end();
    @(negedge clk); cs_rise = 1;
    @(negedge clk); cs_rise = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && wip; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    cold_n = 1; rst_n = 1;
    @(negedge clk);
    check("R1 cold wiper", wiper_code, 10'h2A5);
    check("R1 wip after reset", {9'b0, wip}, 10'h000);
    check("R1 rd after reset", rd_data, 10'h000);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][34:32], VEC[v][31:30], VEC[v][29:20]);
      check($sformatf("R10/R2/R3 vec%0d wiper", v), wiper_code, VEC[v][19:10]);
      check($sformatf("R10 vec%0d rd", v), rd_data, VEC[v][9:0]);
    end

    // R5: no commit before frame end; empty frame end does nothing
    frame_end();
    check("R5 empty frame end", {9'b0, wip}, 10'h000);
    issue(3'd3, 2'd0, 10'h0C3);
    repeat (3) @(negedge clk);
    check("R5 no busy before cs_rise", {9'b0, wip}, 10'h000);
    @(negedge clk); cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    check("R5 wip after cs_rise", {9'b0, wip}, 10'h001);
    n = 0;
    for (int i = 0; i < 100 && wip; i++) begin n++; @(negedge clk); end
    check("R6 busy length", 10'(n), 10'(BUSY));
    issue(3'd2, 2'd0, 10'h000);
    check("R6 value after busy", rd_data, 10'h0C3);

    // R6 old value during busy, R8 store ignored, R2 wiper write while busy
    issue(3'd3, 2'd1, 10'h2D2);
    frame_end();
    issue(3'd2, 2'd1, 10'h000);
    check("R6 old value while busy", rd_data, 10'h155);
    issue(3'd6, 2'd0, 10'h000);
    check("R10 status busy", rd_data, 10'h001);
    issue(3'd3, 2'd2, 10'h111);
    issue(3'd1, 2'd0, 10'h0AB);
    check("R2 wiper write while busy", wiper_code, 10'h0AB);
    frame_end();
    wait_idle();
    repeat (2) @(negedge clk);
    check("R8 no second busy", {9'b0, wip}, 10'h000);
    issue(3'd2, 2'd2, 10'h000);
    check("R8 DR2 untouched", rd_data, 10'h000);
    issue(3'd2, 2'd1, 10'h000);
    check("R6 DR1 committed", rd_data, 10'h2D2);

    // R7 write protect
    wp_n = 0;
    issue(3'd3, 2'd2, 10'h222);
    frame_end();
    check("R7 no busy when protected", {9'b0, wip}, 10'h000);
    issue(3'd1, 2'd0, 10'h1FE);
    check("R7/R2 wiper write under protect", wiper_code, 10'h1FE);
    issue(3'd2, 2'd2, 10'h000);
    check("R7 DR2 unchanged", rd_data, 10'h000);
    wp_n = 1;

    // R9 store of wiper captures value at command time
    issue(3'd1, 2'd0, 10'h1E1);
    issue(3'd5, 2'd3, 10'h000);
    issue(3'd1, 2'd0, 10'h050);
    frame_end();
    check("R9 busy started", {9'b0, wip}, 10'h001);
    wait_idle();
    issue(3'd2, 2'd3, 10'h000);
    check("R9 stored wiper", rd_data, 10'h1E1);

    // R1 warm reset recalls the stored DR0
    issue(3'd1, 2'd0, 10'h3AA);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 warm recall", wiper_code, 10'h0C3);
    issue(3'd2, 2'd1, 10'h000);
    check("R1 DR1 kept over reset", rd_data, 10'h2D2);

    summary();
  end
endmodule